// File: doc/BRIEF.md
# Inter-Processor Interrupt Destination Resolver

This block turns one interrupt command, written as a low and a high 32-bit word, into the set of interrupt controllers that must receive it. It takes the index of the controller that issued the command and a table of N target controllers. Each table entry gives the target's physical ID, its logical ID, its logical-addressing format and an enable flag. One cycle after a command strobe the block presents registered results. For fixed and the other ordinary delivery modes this is a per-target delivery mask. For lowest-priority delivery it is instead a one-hot grant to a single target. It also presents the decoded vector, delivery mode, trigger mode and level bit.

Addressing covers physical IDs with a broadcast value, flat and clustered logical IDs, and four shorthand codes. Lowest-priority arbitration does not compare priorities. A pointer kept inside the block records the last chosen target. The next search starts one place beyond it, wraps around the table, and stops at the first target that both matches and is enabled. Per-target pending state and interrupt acceptance sit in the target controllers and are outside this block.

Top module: `ipi_dest_resolver`

## Requirements
- R1: One cycle after `cmd_valid` is sampled high, `vec` equals low-word bits 7:0, `dlv_mode` equals bits 10:8, `lvl` equals bit 14 and `trig` equals bit 15 of that command.
- R2: `cmd_rb` equals the command low word with bit 12 (the delivery-pending flag) forced to zero, because dispatch finishes at once.
- R3: Low-word bits 19:18 select the shorthand: 0 uses the destination field, 1 matches only the source index, 2 matches every target, 3 matches every target except the source index.
- R4: With shorthand 0 and bit 11 clear (physical mode), a target matches when the destination (high-word bits 31:24) is 0xFF or equals its physical ID.
- R5: With shorthand 0 and bit 11 set, a target whose format is 4'hF (flat) matches when its logical ID AND the destination is nonzero.
- R6: With shorthand 0 and bit 11 set, a target whose format is 4'h0 (cluster) matches when the upper nibbles of its logical ID and of the destination are equal and their lower nibbles share a set bit.
- R7: A target whose format is any value other than 4'hF or 4'h0 never matches in logical mode.
- R8: For delivery mode 3'b001 (lowest priority), `dlv_mask` is zero. `grant` is one-hot on the first target that matches and is enabled, searching from pointer+1 upward and wrapping at N.
- R9: A lowest-priority command moves the pointer to the granted index. When no target qualifies, `grant` is zero and the pointer keeps its value.
- R10: For any other delivery mode, `grant` is zero and `dlv_mask` holds every matching target, whether or not it is enabled.
- R11: After reset every output is zero and the pointer is 0, so the first lowest-priority search begins at index 1.
- R12: `out_valid` is high exactly in the cycle after a cycle with `cmd_valid` high. Without a strobe, all other outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_lo | input | 32 | Command low word |
| cmd_hi | input | 32 | Command high word (destination in 31:24) |
| src_idx | input | IDX_W | Index of the issuing controller |
| tgt_phys_id | input | 8*N_TGT | Physical IDs, target i in bits 8i+7:8i |
| tgt_log_id | input | 8*N_TGT | Logical IDs, target i in bits 8i+7:8i |
| tgt_fmt | input | 4*N_TGT | Logical format, target i in bits 4i+3:4i |
| tgt_en | input | N_TGT | Target enable flags |
| out_valid | output | 1 | Result valid |
| dlv_mask | output | N_TGT | Delivery mask (non-lowest modes) |
| grant | output | N_TGT | One-hot lowest-priority grant |
| vec | output | 8 | Decoded vector |
| dlv_mode | output | 3 | Decoded delivery mode |
| trig | output | 1 | Decoded trigger mode |
| lvl | output | 1 | Decoded level bit |
| cmd_rb | output | 32 | Low-word readback, pending bit clear |

## Verification
The hardest case to reach from the ports is a lowest-priority command that finds no enabled match. The pointer must then stay put, and this only shows in the grant of a later command. The stimulus first walks the pointer to a known place with a run of grants over a table that has one target disabled. It then issues a command addressed only to that disabled target, and follows it with a broadcast whose grant shows where the search restarts. A wrap from the top index back to index 0 is reached the same way, by stepping the pointer to N-1 before the probe.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned VEC_W    = 8;
    localparam int unsigned MODE_W   = 3;
    localparam int unsigned DEST_W   = 8;
    localparam int unsigned FMT_W    = 4;

    localparam int unsigned PEND_BIT = 12;

    localparam logic [FMT_W-1:0]  FMT_FLAT    = 4'hF;
    localparam logic [FMT_W-1:0]  FMT_CLUSTER = 4'h0;
    localparam logic [DEST_W-1:0] DEST_BCAST  = 8'hFF;

    typedef enum logic [1:0] {
        SH_NONE     = 2'd0,
        SH_SELF     = 2'd1,
        SH_ALL      = 2'd2,
        SH_OTHERS   = 2'd3
    } shorthand_e;

    localparam logic [MODE_W-1:0] MODE_LOWEST = 3'b001;

    typedef struct packed {
        logic [VEC_W-1:0]  vec;
        logic [MODE_W-1:0] mode;
        logic              logical;
        logic              level;
        logic              trig;
        shorthand_e        sh;
        logic [DEST_W-1:0] dest;
        logic [WORD_W-1:0] rb;
    } ipi_cmd_t;

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
    import ipi_pkg::*;
(
    input  logic [WORD_W-1:0] lo_word,
    input  logic [WORD_W-1:0] hi_word,
    output ipi_cmd_t          cmd
);

    logic [23:0] unused_hi;

    always_comb begin
        cmd          = '0;
        cmd.vec      = lo_word[7:0];
        cmd.mode     = lo_word[10:8];
        cmd.logical  = lo_word[11];
        cmd.level    = lo_word[14];
        cmd.trig     = lo_word[15];
        cmd.sh       = shorthand_e'(lo_word[19:18]);
        cmd.dest     = hi_word[31:24];
        cmd.rb       = lo_word;
        cmd.rb[PEND_BIT] = 1'b0;
    end

    assign unused_hi = hi_word[23:0];

endmodule

// File: rtl/ipi_tgt_match.sv
module ipi_tgt_match
    import ipi_pkg::*;
#(
    parameter int unsigned IDX_W = 3,
    parameter int unsigned IDX   = 0
) (
    input  shorthand_e        sh,
    input  logic              logical,
    input  logic [DEST_W-1:0] dest,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic [DEST_W-1:0] phys_id,
    input  logic [DEST_W-1:0] log_id,
    input  logic [FMT_W-1:0]  fmt,
    output logic              hit
);

    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(IDX);

    logic is_src;
    logic phys_hit;
    logic flat_hit;
    logic clus_hit;
    logic log_hit;

    always_comb begin
        is_src   = (src_idx == MY_IDX);
        phys_hit = (dest == DEST_BCAST) || (dest == phys_id);
        flat_hit = |(log_id & dest);
        clus_hit = (log_id[7:4] == dest[7:4]) && (|(log_id[3:0] & dest[3:0]));
        unique case (fmt)
            FMT_FLAT:    log_hit = flat_hit;
            FMT_CLUSTER: log_hit = clus_hit;
            default:     log_hit = 1'b0;
        endcase
        unique case (sh)
            SH_NONE:   hit = logical ? log_hit : phys_hit;
            SH_SELF:   hit = is_src;
            SH_ALL:    hit = 1'b1;
            SH_OTHERS: hit = !is_src;
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick #(
    parameter int unsigned N_TGT = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic [N_TGT-1:0] cand,
    input  logic [IDX_W-1:0] ptr,
    output logic             found,
    output logic [IDX_W-1:0] ptr_next,
    output logic [N_TGT-1:0] grant
);

    logic [IDX_W-1:0] pick;

    always_comb begin
        found = 1'b0;
        pick  = ptr;
        for (int k = 1; k <= int'(N_TGT); k++) begin
            int slot;
            slot = (int'(ptr) + k) % int'(N_TGT);
            if (!found && cand[slot]) begin
                found = 1'b1;
                pick  = IDX_W'(slot);
            end
        end
        ptr_next = pick;
        grant    = '0;
        if (found) begin
            grant[pick] = 1'b1;
        end
    end

endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
    import ipi_pkg::*;
#(
    parameter int unsigned N_TGT = 8,
    parameter int unsigned IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [31:0]             cmd_lo,
    input  logic [31:0]             cmd_hi,
    input  logic [IDX_W-1:0]        src_idx,
    input  logic [8*N_TGT-1:0]      tgt_phys_id,
    input  logic [8*N_TGT-1:0]      tgt_log_id,
    input  logic [4*N_TGT-1:0]      tgt_fmt,
    input  logic [N_TGT-1:0]        tgt_en,
    output logic                    out_valid,
    output logic [N_TGT-1:0]        dlv_mask,
    output logic [N_TGT-1:0]        grant,
    output logic [7:0]              vec,
    output logic [2:0]              dlv_mode,
    output logic                    trig,
    output logic                    lvl,
    output logic [31:0]             cmd_rb
);

    typedef struct packed {
        logic               vld;
        logic [N_TGT-1:0]   mask;
        logic [N_TGT-1:0]   grant;
        logic [VEC_W-1:0]   vec;
        logic [MODE_W-1:0]  mode;
        logic               trig;
        logic               lvl;
        logic [WORD_W-1:0]  rb;
        logic [IDX_W-1:0]   ptr;
    } state_t;

    state_t   st_d, st_q;
    ipi_cmd_t cmd;

    logic [N_TGT-1:0] hit_vec;
    logic [N_TGT-1:0] cand;
    logic             rr_found;
    logic [IDX_W-1:0] rr_ptr_next;
    logic [N_TGT-1:0] rr_grant;

    ipi_cmd_decode u_dec (
        .lo_word (cmd_lo),
        .hi_word (cmd_hi),
        .cmd     (cmd)
    );

    for (genvar gi = 0; gi < int'(N_TGT); gi++) begin : g_tgt
        ipi_tgt_match #(
            .IDX_W (IDX_W),
            .IDX   (gi)
        ) u_match (
            .sh      (cmd.sh),
            .logical (cmd.logical),
            .dest    (cmd.dest),
            .src_idx (src_idx),
            .phys_id (tgt_phys_id[8*gi +: 8]),
            .log_id  (tgt_log_id[8*gi +: 8]),
            .fmt     (tgt_fmt[4*gi +: 4]),
            .hit     (hit_vec[gi])
        );
    end

    assign cand = hit_vec & tgt_en;

    ipi_rr_pick #(
        .N_TGT (N_TGT),
        .IDX_W (IDX_W)
    ) u_rr (
        .cand     (cand),
        .ptr      (st_q.ptr),
        .found    (rr_found),
        .ptr_next (rr_ptr_next),
        .grant    (rr_grant)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = cmd_valid;
        if (cmd_valid) begin
            st_d.vec  = cmd.vec;
            st_d.mode = cmd.mode;
            st_d.trig = cmd.trig;
            st_d.lvl  = cmd.level;
            st_d.rb   = cmd.rb;
            if (cmd.mode == MODE_LOWEST) begin
                st_d.mask  = '0;
                st_d.grant = rr_found ? rr_grant : '0;
                st_d.ptr   = rr_ptr_next;
            end else begin
                st_d.mask  = hit_vec;
                st_d.grant = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign dlv_mask  = st_q.mask;
    assign grant     = st_q.grant;
    assign vec       = st_q.vec;
    assign dlv_mode  = st_q.mode;
    assign trig      = st_q.trig;
    assign lvl       = st_q.lvl;
    assign cmd_rb    = st_q.rb;

    // R12: result strobe follows the command strobe by one cycle
    p_valid_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> out_valid);
    p_valid_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !out_valid);

    // R2: readback is the strobed low word with the pending flag cleared
    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (cmd_rb == ($past(cmd_lo) & ~32'h0000_1000)));

    // R8: lowest priority yields at most one grant and no mask
    p_lowest_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && dlv_mode == MODE_LOWEST) |-> ($onehot0(grant) && dlv_mask == '0));

    // R8: a grant never lands on a target that was disabled at the strobe
    p_grant_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> ((grant & ~$past(tgt_en)) == '0));

    // R10: ordinary modes never grant
    p_no_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && dlv_mode != MODE_LOWEST) |-> (grant == '0));

    // R9: an empty lowest-priority grant leaves the pointer where it was
    p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && dlv_mode == MODE_LOWEST && grant == '0) |-> (st_q.ptr == $past(st_q.ptr)));

    // R3: the self shorthand reaches at most one target
    p_self_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cmd_rb[19:18] == 2'd1) |-> ($countones(dlv_mask) <= 1));

endmodule

// File: tb/sim_ipi_dest_resolver.sv
`timescale 1ns/1ps
module sim_ipi_dest_resolver;

    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [31:0]   cmd_lo = '0;
    logic [31:0]   cmd_hi = '0;
    logic [IW-1:0] src_idx = '0;
    logic [8*N-1:0] tgt_phys_id;
    logic [8*N-1:0] tgt_log_id;
    logic [4*N-1:0] tgt_fmt;
    logic [N-1:0]   tgt_en;
    logic           out_valid;
    logic [N-1:0]   dlv_mask;
    logic [N-1:0]   grant;
    logic [7:0]     vec;
    logic [2:0]     dlv_mode;
    logic           trig;
    logic           lvl;
    logic [31:0]    cmd_rb;

    int phys[N];
    int logid[N];
    int fmt[N];
    bit en[N];

    int total = 0;
    int bad = 0;
    bit done = 0;

    int ref_ptr = 0;
    bit e_valid = 0;
    int e_mask = 0, e_grant = 0, e_vec = 0, e_mode = 0, e_trig = 0, e_lvl = 0;
    longint e_rb = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            tgt_phys_id[8*i +: 8] = 8'(phys[i]);
            tgt_log_id[8*i +: 8]  = 8'(logid[i]);
            tgt_fmt[4*i +: 4]     = 4'(fmt[i]);
            tgt_en[i]             = en[i];
        end
    end

    ipi_dest_resolver #(.N_TGT(N)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_lo(cmd_lo),
        .cmd_hi(cmd_hi), .src_idx(src_idx), .tgt_phys_id(tgt_phys_id),
        .tgt_log_id(tgt_log_id), .tgt_fmt(tgt_fmt), .tgt_en(tgt_en),
        .out_valid(out_valid), .dlv_mask(dlv_mask), .grant(grant), .vec(vec),
        .dlv_mode(dlv_mode), .trig(trig), .lvl(lvl), .cmd_rb(cmd_rb)
    );

    function automatic bit ref_hit(int t, int lo, int hi, int src);
        int sh   = (lo >> 18) & 3;
        int dst  = (hi >> 24) & 255;
        bit lgc  = ((lo >> 11) & 1) != 0;
        if (sh == 1) return t == src;
        if (sh == 2) return 1;
        if (sh == 3) return t != src;
        if (!lgc) return (dst == 255) || (dst == phys[t]);
        if (fmt[t] == 15) return (logid[t] & dst) != 0;
        if (fmt[t] == 0)
            return ((logid[t] / 16) == (dst / 16)) && ((logid[t] & dst & 15) != 0);
        return 0;
    endfunction

    task automatic model(bit v, int lo, int hi, int src);
        e_valid = v;
        if (!v) return;
        e_vec  = lo & 255;
        e_mode = (lo >> 8) & 7;
        e_lvl  = (lo >> 14) & 1;
        e_trig = (lo >> 15) & 1;
        e_rb   = longint'(lo) & 64'hFFFF_EFFF;
        e_mask = 0;
        e_grant = 0;
        if (e_mode == 1) begin
            for (int s = 1; s <= N; s++) begin
                int j = (ref_ptr + s) % N;
                if (ref_hit(j, lo, hi, src) && en[j]) begin
                    e_grant = 1 << j;
                    ref_ptr = j;
                    break;
                end
            end
        end else begin
            for (int t = 0; t < N; t++)
                if (ref_hit(t, lo, hi, src)) e_mask |= (1 << t);
        end
    endtask

    task automatic chk(string tag, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk("R12", "out_valid", longint'(out_valid), longint'(e_valid));
        chk(tag, "dlv_mask", longint'(dlv_mask), longint'(e_mask));
        chk(tag, "grant", longint'(grant), longint'(e_grant));
        chk("R1", "vec", longint'(vec), longint'(e_vec));
        chk("R1", "dlv_mode", longint'(dlv_mode), longint'(e_mode));
        chk("R1", "trig", longint'(trig), longint'(e_trig));
        chk("R1", "lvl", longint'(lvl), longint'(e_lvl));
        chk("R2", "cmd_rb", longint'(cmd_rb), e_rb);
    endtask

    task automatic step(bit v, int lo, int hi, int src, string tag);
        cmd_valid = v;
        cmd_lo    = 32'(lo);
        cmd_hi    = 32'(hi);
        src_idx   = IW'(src);
        model(v, lo, hi, src);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    function automatic int lw(int vecv, int mode, bit lgc, bit lv, bit tr, int sh, bit pend);
        return vecv | (mode << 8) | (int'(lgc) << 11) | (int'(pend) << 12)
             | (int'(lv) << 14) | (int'(tr) << 15) | (sh << 18);
    endfunction

    function automatic int hw(int d);
        return d << 24;
    endfunction

    initial begin
        #(100000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            phys[i]  = 2 * i;
            logid[i] = 1 << i;
            fmt[i]   = 15;
            en[i]    = 1;
        end
        logid[6] = 8'h21; fmt[6] = 0;
        logid[7] = 8'hFF; fmt[7] = 5;
        en[2] = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state, all outputs zero
        compare("R11");

        // R4: physical exact match and broadcast; R1 field decode
        step(1, lw(8'h41, 0, 0, 1, 0, 0, 0), hw(8'h06), 0, "R4");
        step(1, lw(8'h99, 0, 0, 0, 1, 0, 0), hw(8'hFF), 1, "R4");
        step(1, lw(8'h10, 0, 0, 0, 0, 0, 0), hw(8'h05), 1, "R4");
        // R12: idle cycles hold outputs
        step(0, 0, 0, 0, "R12");
        step(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3, "R12");

        // R5 and R7: flat logical, invalid-format target never matches
        step(1, lw(8'h22, 0, 1, 0, 0, 0, 0), hw(8'h0F), 0, "R5");
        step(1, lw(8'h22, 0, 1, 0, 0, 0, 0), hw(8'h80), 0, "R7");
        // R6: cluster logical hit and miss on upper nibble
        step(1, lw(8'h23, 0, 1, 1, 1, 0, 0), hw(8'h23), 0, "R6");
        step(1, lw(8'h23, 0, 1, 0, 0, 0, 0), hw(8'h31), 0, "R6");

        // R3: shorthands
        step(1, lw(8'h30, 0, 0, 0, 0, 1, 0), hw(8'h00), 5, "R3");
        step(1, lw(8'h31, 0, 0, 0, 0, 2, 0), hw(8'h00), 5, "R3");
        step(1, lw(8'h32, 0, 0, 0, 0, 3, 0), hw(8'h00), 5, "R3");

        // R2: pending bit written as one reads back clear
        step(1, lw(8'hAA, 4, 0, 1, 1, 0, 1), hw(8'h02), 0, "R2");

        // R10: mask ignores enable (target 2 disabled)
        step(1, lw(8'h50, 0, 0, 0, 0, 0, 0), hw(8'h04), 0, "R10");

        // R8 and R11: lowest priority walks from index 1, skips disabled target 2
        for (int r = 0; r < 5; r++)
            step(1, lw(8'h60, 1, 0, 0, 0, 0, 0), hw(8'hFF), 0, "R8");
        // R9: only the disabled target matches; empty grant, pointer kept
        step(1, lw(8'h61, 1, 0, 0, 0, 0, 0), hw(8'h04), 0, "R9");
        step(1, lw(8'h62, 1, 0, 0, 0, 0, 0), hw(8'hFF), 0, "R9");
        // R8: wrap past N-1 back to index 0
        step(1, lw(8'h63, 1, 0, 0, 0, 0, 0), hw(8'hFF), 0, "R8");
        step(1, lw(8'h64, 1, 0, 0, 0, 0, 0), hw(8'hFF), 0, "R8");
        // R8: lowest priority with flat logical subset and all-but-self
        step(1, lw(8'h65, 1, 1, 0, 0, 0, 0), hw(8'h30), 0, "R8");
        step(1, lw(8'h66, 1, 0, 0, 0, 3, 0), hw(8'h00), 5, "R8");
        en[4] = 0;
        step(1, lw(8'h67, 1, 1, 0, 0, 0, 0), hw(8'h30), 0, "R8");
        step(1, lw(8'h68, 1, 0, 0, 0, 1, 0), hw(8'h00), 2, "R9");
        step(0, 0, 0, 0, "R12");

        // R11: reset mid-run clears outputs and pointer
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        ref_ptr = 0;
        model(0, 0, 0, 0);
        e_mask = 0; e_grant = 0; e_vec = 0; e_mode = 0; e_trig = 0; e_lvl = 0; e_rb = 0;
        compare("R11");
        step(1, lw(8'h70, 1, 0, 0, 0, 0, 0), hw(8'hFF), 0, "R11");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule